// File: doc/BRIEF.md
# Mixed-Radix In-Place FFT Address Generator

This block sequences the memory traffic of one pass of an in-place FFT built from radix-4 and radix-2 butterflies. A pass controller hands it a configuration (transform size, radix, leg spacing and an optional bit-reversal mode) and a start pulse. The block then walks a plain binary operation counter through every point of the transform. Each counter value is mapped through a bit-field permutation network to a RAM data address, one per cycle. Once per butterfly group it also produces a twiddle coefficient address.

Every pass uses the same counter and permutation unit, whatever its radix or spacing. Results return to the locations they were read from. The write address stream is therefore the read address stream, delayed by the fixed latency of the arithmetic that sits between read and write. The configuration is captured at start and stays fixed until the pass ends. A start pulse that arrives mid-pass is discarded.

Top module: `fft_addr_gen`

## Requirements
- R1: While reset is held, and after it is released, `busy`, `rd_valid`, `coef_valid`, `pass_done` and `wr_valid` are all low.
- R2: If `start` is high on an edge while the block is idle, the configuration is captured and `busy` is high after that edge. `rd_valid` is high for exactly N = 2^`cfg_log2n` consecutive cycles, and the first of these begins one edge later. No other read is issued.
- R3: In butterfly mode (`cfg_reverse`=0), let r be 4 when `cfg_radix4`=1 and 2 otherwise, and let S = 2^`cfg_span`. For counter value c, the leg is k = c mod r and the group is g = c / r. The read address is (g / S)·r·S + (g mod S) + k·S, and `rd_leg` carries k.
- R4: An 8-point transform reads 0,2,4,6,1,3,5,7 in its radix-4 pass (S=2). It reads 0,1,...,7 in its radix-2 pass (S=1).
- R5: In butterfly mode, `coef_valid` is high exactly on leg 0 of each group. With it, `coef_addr` = (g mod S)·N/(r·S), so the first group of every block of r·S points uses coefficient 0.
- R6: In reverse mode (`cfg_reverse`=1), the read address for counter value c is c with its low `cfg_log2n` bits in reversed order. In this mode `rd_leg` is 0 and `coef_valid` stays low.
- R7: `pass_done` is a single-cycle pulse that coincides with the read for c = N-1. `busy` is low in that same cycle.
- R8: `wr_valid` and `wr_addr` repeat `rd_valid` and `rd_addr` exactly WB_LAT cycles later (default 3), so every result lands on the address it was read from.
- R9: A `start` pulse, or a change on the configuration inputs, while `busy` is high has no effect on the running pass or its address stream.
- R10: Every size from 8 (`cfg_log2n`=3) to 256 (`cfg_log2n`=8) points is supported, including spacings up to S = N/r.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a pass with the present configuration |
| cfg_log2n | input | 4 | log2 of the transform size, 3 to 8 |
| cfg_radix4 | input | 1 | 1 selects radix-4 butterflies, 0 selects radix-2 |
| cfg_span | input | 3 | log2 of the spacing S between butterfly legs |
| cfg_reverse | input | 1 | 1 selects the bit-reversed reordering walk |
| busy | output | 1 | A pass is being counted |
| rd_valid | output | 1 | `rd_addr` is valid this cycle |
| rd_addr | output | 8 | Data read address |
| rd_leg | output | 2 | Butterfly leg of the current read |
| coef_valid | output | 1 | `coef_addr` is valid (leg 0 of a group) |
| coef_addr | output | 8 | Twiddle coefficient address for the group |
| pass_done | output | 1 | Last read of the pass |
| wr_valid | output | 1 | `wr_addr` is valid this cycle |
| wr_addr | output | 8 | In-place write address |

## Verification
The hardest case to reach is a start request that arrives while a pass is still running, together with moving configuration inputs. Nothing at the ports shows that the request was dropped, except that the address stream goes on unchanged. The stimulus launches a 32-point pass and, a few cycles later, raises `start` again with a different size, radix and spacing on the inputs. The scoreboard still expects the original pass's addresses, so a restart or a re-capture would break the stream. The extreme spacings S = N/r at 256 points are also driven, since they exercise the widest bit fields of the permutation.

// File: rtl/fftag_pkg.sv
package fftag_pkg;
    localparam int LOG2N_W = 4;
    localparam int SPAN_W  = 3;

    typedef struct packed {
        logic [LOG2N_W-1:0] log2n;
        logic               radix4;
        logic [SPAN_W-1:0]  span;
        logic               reverse;
    } pass_cfg_t;
endpackage

// File: rtl/fftag_counter.sv
module fftag_counter
    import fftag_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  pass_cfg_t     cfg_in,
    output logic          busy,
    output logic          last,
    output logic [AW-1:0] cnt,
    output pass_cfg_t     cfg
);
    typedef struct packed {
        logic          busy;
        logic [AW-1:0] cnt;
        pass_cfg_t     cfg;
    } state_t;

    state_t        st_d, st_q;
    logic [AW:0]   n_full;
    logic [AW-1:0] cnt_max;

    always_comb begin
        n_full  = (AW+1)'(1) << st_q.cfg.log2n;
        cnt_max = AW'(n_full - (AW+1)'(1));
        last    = st_q.cnt == cnt_max;
        st_d    = st_q;
        if (!st_q.busy) begin
            if (start) begin
                st_d.busy = 1'b1;
                st_d.cnt  = '0;
                st_d.cfg  = cfg_in;
            end
        end else if (last) begin
            st_d.busy = 1'b0;
        end else begin
            st_d.cnt = st_q.cnt + AW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy = st_q.busy;
    assign cnt  = st_q.cnt;
    assign cfg  = st_q.cfg;

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && !last) |=> (st_q.busy && st_q.cnt == $past(st_q.cnt) + AW'(1))); // R2

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && start) |=> $stable(st_q.cfg)); // R9
endmodule

// File: rtl/fftag_perm.sv
module fftag_perm
    import fftag_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic [AW-1:0] cnt,
    input  pass_cfg_t     cfg,
    output logic [AW-1:0] addr,
    output logic [1:0]    leg,
    output logic          first_leg,
    output logic [AW-1:0] coef
);
    logic [AW-1:0] rev_full;
    logic [AW-1:0] grp, kval, glo, ghi, bf_addr, rev_addr, coef_raw;
    int            lr, sp, csh;

    generate
        for (genvar i = 0; i < AW; i++) begin : g_rev
            assign rev_full[i] = cnt[AW-1-i];
        end
    endgenerate

    always_comb begin
        lr  = cfg.radix4 ? 2 : 1;
        sp  = int'(cfg.span);
        csh = int'(cfg.log2n) - lr - sp;
        if (csh < 0) begin
            csh = 0;
        end
        grp      = cnt >> lr;
        kval     = cnt & ((AW'(1) << lr) - AW'(1));
        glo      = grp & ((AW'(1) << sp) - AW'(1));
        ghi      = grp >> sp;
        bf_addr  = (ghi << (sp + lr)) | (kval << sp) | glo;
        rev_addr = rev_full >> (AW - int'(cfg.log2n));
        coef_raw = glo << csh;
        if (cfg.reverse) begin
            addr      = rev_addr;
            leg       = 2'd0;
            first_leg = 1'b0;
            coef      = '0;
        end else begin
            addr      = bf_addr;
            leg       = kval[1:0];
            first_leg = kval == '0;
            coef      = coef_raw;
        end
    end
endmodule

// File: rtl/fftag_wrdelay.sv
module fftag_wrdelay #(
    parameter int AW  = 8,
    parameter int LAT = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [AW-1:0] in_addr,
    output logic          out_valid,
    output logic [AW-1:0] out_addr
);
    logic [LAT-1:0] v_q;
    logic [AW-1:0]  a_q [LAT];

    generate
        for (genvar i = 0; i < LAT; i++) begin : g_stage
            logic          v_d;
            logic [AW-1:0] a_d;
            if (i == 0) begin : g_head
                assign v_d = in_valid;
                assign a_d = in_addr;
            end else begin : g_tail
                assign v_d = v_q[i-1];
                assign a_d = a_q[i-1];
            end
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    v_q[i] <= 1'b0;
                    a_q[i] <= '0;
                end else begin
                    v_q[i] <= v_d;
                    a_q[i] <= a_d;
                end
            end
        end
    endgenerate

    assign out_valid = v_q[LAT-1];
    assign out_addr  = a_q[LAT-1];
endmodule

// File: rtl/fft_addr_gen.sv
module fft_addr_gen
    import fftag_pkg::*;
#(
    parameter int AW     = 8,
    parameter int WB_LAT = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [3:0]    cfg_log2n,
    input  logic          cfg_radix4,
    input  logic [2:0]    cfg_span,
    input  logic          cfg_reverse,
    output logic          busy,
    output logic          rd_valid,
    output logic [AW-1:0] rd_addr,
    output logic [1:0]    rd_leg,
    output logic          coef_valid,
    output logic [AW-1:0] coef_addr,
    output logic          pass_done,
    output logic          wr_valid,
    output logic [AW-1:0] wr_addr
);
    typedef struct packed {
        logic          rd_valid;
        logic [AW-1:0] rd_addr;
        logic [1:0]    rd_leg;
        logic          coef_valid;
        logic [AW-1:0] coef_addr;
        logic          pass_done;
    } out_t;

    pass_cfg_t     cfg_in, cfg_q;
    logic          busy_q, last;
    logic [AW-1:0] cnt_q, p_addr, p_coef;
    logic [1:0]    p_leg;
    logic          p_first;
    logic [AW:0]   n_full;
    out_t          out_d, out_q;

    assign cfg_in = '{log2n: cfg_log2n, radix4: cfg_radix4, span: cfg_span, reverse: cfg_reverse};

    fftag_counter #(.AW(AW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_in(cfg_in),
        .busy(busy_q), .last(last), .cnt(cnt_q), .cfg(cfg_q)
    );

    fftag_perm #(.AW(AW)) u_perm (
        .cnt(cnt_q), .cfg(cfg_q), .addr(p_addr), .leg(p_leg),
        .first_leg(p_first), .coef(p_coef)
    );

    always_comb begin
        out_d            = '0;
        out_d.rd_valid   = busy_q;
        out_d.rd_addr    = busy_q ? p_addr : '0;
        out_d.rd_leg     = busy_q ? p_leg : 2'd0;
        out_d.coef_valid = busy_q && p_first;
        out_d.coef_addr  = (busy_q && p_first) ? p_coef : '0;
        out_d.pass_done  = busy_q && last;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    fftag_wrdelay #(.AW(AW), .LAT(WB_LAT)) u_wr (
        .clk(clk), .rst_n(rst_n), .in_valid(out_q.rd_valid), .in_addr(out_q.rd_addr),
        .out_valid(wr_valid), .out_addr(wr_addr)
    );

    assign busy       = busy_q;
    assign rd_valid   = out_q.rd_valid;
    assign rd_addr    = out_q.rd_addr;
    assign rd_leg     = out_q.rd_leg;
    assign coef_valid = out_q.coef_valid;
    assign coef_addr  = out_q.coef_addr;
    assign pass_done  = out_q.pass_done;

    assign n_full = (AW+1)'(1) << cfg_q.log2n;

    AST_ADDR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> ({1'b0, rd_addr} < n_full)); // R3

    AST_COEF_FIRST_LEG: assert property (@(posedge clk) disable iff (!rst_n)
        coef_valid |-> (rd_valid && rd_leg == 2'd0)); // R5

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        pass_done |=> !pass_done); // R7

    AST_DONE_WITH_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        pass_done |-> (rd_valid && !busy)); // R7
endmodule

// File: tb/fft_addr_gen_test.sv
`timescale 1ns/1ps
module fft_addr_gen_test;
    localparam int AW  = 8;
    localparam int LAT = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [3:0]    cfg_log2n = 4'd3;
    logic          cfg_radix4 = 1'b0;
    logic [2:0]    cfg_span = 3'd0;
    logic          cfg_reverse = 1'b0;
    logic          busy, rd_valid, coef_valid, pass_done, wr_valid;
    logic [AW-1:0] rd_addr, coef_addr, wr_addr;
    logic [1:0]    rd_leg;

    fft_addr_gen #(.AW(AW), .WB_LAT(LAT)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_log2n(cfg_log2n),
        .cfg_radix4(cfg_radix4), .cfg_span(cfg_span), .cfg_reverse(cfg_reverse),
        .busy(busy), .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_leg(rd_leg),
        .coef_valid(coef_valid), .coef_addr(coef_addr), .pass_done(pass_done),
        .wr_valid(wr_valid), .wr_addr(wr_addr)
    );

    always #2 clk = ~clk;

    typedef struct {
        int    addr;
        int    leg;
        bit    cv;
        int    coef;
        bit    done;
        string tag;
    } exp_t;
    typedef struct {
        int addr;
        int cyc;
    } wexp_t;

    exp_t  rd_q[$];
    wexp_t wr_q[$];
    exp_t  e;
    wexp_t w;
    int    checks = 0;
    int    errors = 0;
    int    cyc = 0;

    always @(posedge clk) cyc++;

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Monitor: compares the design's streams against the scoreboard queues.
    always @(negedge clk) begin
        if (rst_n) begin
            if (rd_valid) begin
                if (rd_q.size() == 0) begin
                    chk(1'b0, "R2", "unexpected read", int'(rd_addr), -1);
                end else begin
                    e = rd_q.pop_front();
                    chk(int'(rd_addr) == e.addr, e.tag, "rd_addr", int'(rd_addr), e.addr);
                    chk(int'(rd_leg) == e.leg, e.tag, "rd_leg", int'(rd_leg), e.leg);
                    chk(coef_valid == e.cv, "R5", "coef_valid", int'(coef_valid), int'(e.cv));
                    if (e.cv) chk(int'(coef_addr) == e.coef, "R5", "coef_addr", int'(coef_addr), e.coef);
                    chk(pass_done == e.done, "R7", "pass_done", int'(pass_done), int'(e.done));
                    wr_q.push_back('{addr: e.addr, cyc: cyc});
                end
            end else if (pass_done) begin
                chk(1'b0, "R7", "pass_done without read", 1, 0);
            end
            if (wr_valid) begin
                if (wr_q.size() == 0) begin
                    chk(1'b0, "R8", "unexpected write", int'(wr_addr), -1);
                end else begin
                    w = wr_q.pop_front();
                    chk(int'(wr_addr) == w.addr, "R8", "wr_addr", int'(wr_addr), w.addr);
                    chk(cyc - w.cyc == LAT, "R8", "write delay", cyc - w.cyc, LAT);
                end
            end
        end
    end

    // Driver: pushes the expected stream of one pass, then launches it.
    task automatic run_pass(input int l2n, input bit r4, input int sp, input bit rev,
                            input bit probe, input string tag);
        int n;
        int r;
        int s;
        n = 1 << l2n;
        r = r4 ? 4 : 2;
        s = 1 << sp;
        for (int c = 0; c < n; c++) begin
            exp_t x;
            x.done = (c == n - 1);
            x.tag  = tag;
            if (rev) begin
                int a;
                a = 0;
                for (int b = 0; b < l2n; b++) if (c[b]) a |= 1 << (l2n - 1 - b);
                x.addr = a;
                x.leg  = 0;
                x.cv   = 1'b0;
                x.coef = 0;
            end else begin
                int k;
                int g;
                k = c % r;
                g = c / r;
                x.addr = (g / s) * r * s + (g % s) + k * s;
                x.leg  = k;
                x.cv   = (k == 0);
                x.coef = (g % s) * (n / (r * s));
            end
            rd_q.push_back(x);
        end
        @(negedge clk);
        cfg_log2n   = 4'(l2n);
        cfg_radix4  = r4;
        cfg_span    = 3'(sp);
        cfg_reverse = rev;
        start       = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R2", "busy after start", int'(busy), 1);
        chk(rd_valid == 1'b0, "R2", "no read yet", int'(rd_valid), 0);
        if (probe) begin
            repeat (3) @(negedge clk);
            // R9: restart attempt with a different configuration mid-pass
            cfg_log2n   = 4'd8;
            cfg_radix4  = ~r4;
            cfg_span    = 3'd0;
            cfg_reverse = ~rev;
            start       = 1'b1;
            @(negedge clk);
            start = 1'b0;
            chk(busy == 1'b1, "R9", "busy kept", int'(busy), 1);
        end
        while (!pass_done) @(negedge clk);
        chk(busy == 1'b0, "R7", "busy low at done", int'(busy), 0);
        repeat (LAT + 2) @(negedge clk);
        chk(rd_q.size() == 0, tag, "reads missing", rd_q.size(), 0);
        chk(wr_q.size() == 0, "R8", "writes missing", wr_q.size(), 0);
        chk(busy == 1'b0 && rd_valid == 1'b0, "R2", "idle after pass", int'(busy), 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(busy == 1'b0, "R1", "busy", int'(busy), 0);
        chk(rd_valid == 1'b0 && coef_valid == 1'b0, "R1", "rd/coef valid", int'(rd_valid), 0);
        chk(pass_done == 1'b0 && wr_valid == 1'b0, "R1", "done/wr valid", int'(pass_done), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(busy == 1'b0 && rd_valid == 1'b0, "R1", "idle after reset", int'(busy), 0);

        run_pass(3, 1'b1, 1, 1'b0, 1'b0, "R4");   // 0,2,4,6,1,3,5,7
        run_pass(3, 1'b0, 0, 1'b0, 1'b0, "R4");   // 0..7
        run_pass(4, 1'b0, 2, 1'b0, 1'b0, "R3");
        run_pass(6, 1'b1, 2, 1'b0, 1'b0, "R3");
        run_pass(5, 1'b0, 3, 1'b0, 1'b1, "R9");
        run_pass(8, 1'b1, 0, 1'b0, 1'b0, "R10");
        run_pass(8, 1'b1, 6, 1'b0, 1'b0, "R10");
        run_pass(8, 1'b0, 7, 1'b0, 1'b0, "R10");
        run_pass(3, 1'b0, 0, 1'b1, 1'b0, "R6");
        run_pass(8, 1'b0, 0, 1'b1, 1'b0, "R6");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual %0d expected %0d", cyc, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule